// File: doc/BRIEF.md
# I2C Burst-Read Register Slave

This block is an I2C target that gives a bus master fast access to a bank of 32-bit result registers. An access has two phases. In the first phase the master writes a 16-bit register pointer. In the second phase the master issues a repeated START and reads. The block then streams the addressed register out one byte at a time. When the master acknowledges the final byte of a register, the pointer moves to the next register and that register follows.

The block watches SCL and SDA from the system clock domain. It never drives SCL. It pulls SDA low through an open-drain style enable. It fetches register contents through a plain read port: the pointer is presented as an address, and the selected 32-bit word is returned on a data input.

Top module: `i2c_burst_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_addr` is 0x0000.
- R2: The device address is 0x38. The block acknowledges an address byte of 0x70 (write) or 0x71 (read) by pulling SDA low in the ninth clock. It does not acknowledge any other address byte, and it then ignores the rest of that transaction, so `reg_addr` does not change.
- R3: After a write address, the block takes two pointer bytes, high byte first, and acknowledges each one. When the second byte has been taken, `reg_addr` equals the 16-bit pointer. The pointer changes only while a pointer byte is being received or while a master acknowledge is being taken.
- R4: After a repeated START and an acknowledged read address, the block sends the register at `reg_addr` as four bytes. The most significant byte comes first, and each byte is sent most significant bit first.
- R5: If the master acknowledges the fourth byte of a register, the pointer advances by exactly one and the next register is sent. An advance always moves the pointer by exactly one.
- R6: The pointer advances only while it lies in the burst window 0xE880 to 0xE89E. At 0xE89F, or outside the window, an acknowledged last byte leaves the pointer unchanged, so the same register is sent again.
- R7: If the master does not acknowledge the fourth byte, the block releases SDA. It keeps SDA released until the next START or STOP, so any further bytes read back as 0xFF.
- R8: If the master does not acknowledge the first, second or third byte of a register, the block stops transmitting. It releases SDA for the remaining bytes, and the pointer does not advance.
- R9: A register's value is captured when its first byte begins. A change on `reg_data` later in that register does not alter the bytes sent.
- R10: A STOP returns the block to idle with SDA released. While idle, the block does not acknowledge bytes that are not preceded by a START.
- R11: The block turns on its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run at least 8 times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level observed on the bus |
| sda_i | input | 1 | SDA level observed on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases SDA |
| reg_addr | output | 16 | Register pointer presented to the register bank |
| reg_data | input | 32 | Word returned by the register bank for `reg_addr` |

## Verification
The bound checker checks the following on every cycle:
- the pull-down turns on only while the synchronized SCL is low;
- SDA stays released in idle and in the ignoring state;
- a STOP always lands in idle;
- the pointer moves only in the receive and master-acknowledge states, and only by one;
- the pointer never moves once it sits at the window end.

The values of the streamed bytes and the byte order need the bench's scenarios, because they are only visible as bus traffic compared against a model of the register bank. The same holds for:
- the capture of a register at its first byte;
- the handling of mismatched addresses;
- the different endings after a missing acknowledge.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in address byte
    ST_AACK,   // driving ACK for address
    ST_RX,     // shifting in a pointer byte
    ST_RACK,   // driving ACK for a pointer byte
    ST_TX,     // shifting out a data byte
    ST_MACK,   // sampling the master acknowledge
    ST_WAIT    // ignoring bus until START/STOP
  } bus_st_t;

endpackage

// File: rtl/i2cbr_line_sync.sv
module i2cbr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cbr_ptr.sv
module i2cbr_ptr #(
  parameter int               PTR_W     = 16,
  parameter logic [PTR_W-1:0] WIN_FIRST = 16'hE880,
  parameter logic [PTR_W-1:0] WIN_LAST  = 16'hE89F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_hi,
  input  logic             load_lo,
  input  logic [7:0]       byte_in,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr
);

  logic in_window;
  assign in_window = (ptr >= WIN_FIRST) && (ptr < WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load_hi) begin
      ptr[PTR_W-1:8] <= byte_in[PTR_W-9:0];
    end else if (load_lo) begin
      ptr[7:0] <= byte_in;
    end else if (advance && in_window) begin
      ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/i2cbr_txsr.sv
module i2cbr_txsr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              msb,
  output logic              next_msb
);

  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= load_val;
    end else if (shift) begin
      sr <= {sr[DATA_W-2:0], 1'b0};
    end
  end

  assign msb      = sr[DATA_W-1];
  assign next_msb = sr[DATA_W-2];

endmodule

// File: rtl/i2c_burst_slave.sv
module i2c_burst_slave
  import i2cbr_pkg::*;
#(
  parameter logic [6:0]       DEV_ADDR    = 7'h38,
  parameter int               PTR_W       = 16,
  parameter int               DATA_W      = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [PTR_W-1:0] WIN_FIRST   = 16'hE880,
  parameter logic [PTR_W-1:0] WIN_LAST    = 16'hE89F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_data
);

  localparam int            BYTES     = DATA_W / 8;
  localparam int            RB_W      = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [RB_W-1:0] LAST_BYTE = RB_W'(BYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cbr_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  bus_st_t        st;
  logic [3:0]     bitcnt;
  logic [7:0]     rx_sr;
  logic           rw;
  logic [1:0]     pbyte;
  logic [RB_W-1:0] reg_byte;
  logic           ack_r;

  logic evt_clear, last_byte;
  logic ptr_ld_hi, ptr_ld_lo, ptr_adv;
  logic tx_load, tx_shift, tx_msb, tx_next;

  assign evt_clear = start_det | stop_det;
  assign last_byte = (reg_byte == LAST_BYTE);

  assign ptr_ld_hi = !evt_clear && (st == ST_RX) && scl_fall &&
                     (bitcnt == 4'd8) && (pbyte == 2'd0);
  assign ptr_ld_lo = !evt_clear && (st == ST_RX) && scl_fall &&
                     (bitcnt == 4'd8) && (pbyte == 2'd1);
  // advance on the rising SCL of the acknowledge, giving the bank
  // the rest of that clock to present the next word
  assign ptr_adv   = !evt_clear && (st == ST_MACK) && scl_rise &&
                     !sda_s && last_byte;
  assign tx_load   = !evt_clear && scl_fall &&
                     (((st == ST_AACK) && rw) ||
                      ((st == ST_MACK) && ack_r && last_byte));
  assign tx_shift  = !evt_clear && scl_fall &&
                     (((st == ST_TX) && (bitcnt != 4'd8)) ||
                      ((st == ST_MACK) && ack_r && !last_byte));

  i2cbr_ptr #(
    .PTR_W    (PTR_W),
    .WIN_FIRST(WIN_FIRST),
    .WIN_LAST (WIN_LAST)
  ) ptr_i (
    .clk    (clk),
    .rst    (rst),
    .load_hi(ptr_ld_hi),
    .load_lo(ptr_ld_lo),
    .byte_in(rx_sr),
    .advance(ptr_adv),
    .ptr    (reg_addr)
  );

  i2cbr_txsr #(.DATA_W(DATA_W)) txsr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tx_load),
    .load_val(reg_data),
    .shift   (tx_shift),
    .msb     (tx_msb),
    .next_msb(tx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      rx_sr    <= '0;
      rw       <= 1'b0;
      pbyte    <= '0;
      reg_byte <= '0;
      ack_r    <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      sda_oe <= 1'b0;
      bitcnt <= '0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sr  <= {rx_sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (rx_sr[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= rx_sr[0];
              st     <= ST_AACK;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              sda_oe   <= ~reg_data[DATA_W-1];
              reg_byte <= '0;
              st       <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              pbyte  <= '0;
              st     <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            rx_sr  <= {rx_sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (pbyte < 2'd2) begin
              sda_oe <= 1'b1;
              pbyte  <= pbyte + 2'd1;
              st     <= ST_RACK;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              sda_oe <= ~tx_next;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ack_r <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_r) begin
              bitcnt <= '0;
              st     <= ST_TX;
              if (last_byte) begin
                sda_oe   <= ~reg_data[DATA_W-1];
                reg_byte <= '0;
              end else begin
                sda_oe   <= ~tx_next;
                reg_byte <= reg_byte + 1'b1;
              end
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // tx_msb mirrors the bit currently on the bus; kept for visibility
  logic unused_ok;
  assign unused_ok = tx_msb;

endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk
  import i2cbr_pkg::*;
#(
  parameter int               PTR_W    = 16,
  parameter logic [PTR_W-1:0] WIN_LAST = 16'hE89F
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             stop_det,
  input logic             sda_oe,
  input bus_st_t          st,
  input logic [PTR_W-1:0] reg_addr
);

  // R11
  pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R10
  stop_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == ST_IDLE) && !sda_oe);

  // R7
  quiet_states_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe);

  // R5
  step_of_one_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_MACK && reg_addr != $past(reg_addr)) |->
      reg_addr == PTR_W'($past(reg_addr) + 1'b1));

  // R6
  window_end_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_MACK && $past(reg_addr) == WIN_LAST) |->
      reg_addr == WIN_LAST);

  // R3
  ptr_moves_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) != ST_RX && $past(st) != ST_MACK) |-> $stable(reg_addr));

endmodule

bind i2c_burst_slave i2cbr_chk #(
  .PTR_W   (PTR_W),
  .WIN_LAST(WIN_LAST)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .scl_s   (scl_s),
  .stop_det(stop_det),
  .sda_oe  (sda_oe),
  .st      (st),
  .reg_addr(reg_addr)
);

// File: tb/i2c_burst_slave_tb.sv
`timescale 1ns/1ps
module i2c_burst_slave_tb_top;

  localparam int Q  = 10;       // clk cycles per quarter SCL bit
  localparam int WD = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        m_scl, m_sda;
  logic        sda_oe;
  logic [15:0] reg_addr;
  logic [31:0] reg_data;
  logic [31:0] bank_xor;
  logic        sda_bus;

  int checks   = 0;
  int failures = 0;
  int viol     = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [31:0] bank_val(input logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  assign sda_bus  = m_sda & ~sda_oe;
  assign reg_data = bank_val(reg_addr) ^ bank_xor;

  i2c_burst_slave dut_i (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (m_scl),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .reg_addr(reg_addr),
    .reg_data(reg_data)
  );

  // R11 monitor: pull-down must not switch on while SCL is high
  always @(posedge clk) begin
    if (!rst && sda_oe && !oe_prev && m_scl) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      rbit(s);
      b[i] = s;
    end
    wbit(~give_ack);
  endtask

  task automatic set_ptr(input logic [15:0] p, output logic [2:0] acks);
    bus_start();
    wbyte(8'h70, acks[2]);
    wbyte(p[15:8], acks[1]);
    wbyte(p[7:0], acks[0]);
  endtask

  task automatic read_reg(input logic is_last, output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rbyte(!(is_last && k == 3), b);
      v = {v[23:0], b};
    end
  endtask

  // stimulus vectors: {start pointer, register count}
  localparam logic [31:0] VEC [4] = '{
    {16'hE880, 16'd1},
    {16'hE881, 16'd3},
    {16'hE89E, 16'd3},
    {16'h0010, 16'd2}
  };

  initial begin
    repeat (WD) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0]  acks;
    logic        a;
    logic [31:0] v;
    logic [7:0]  b;
    logic [15:0] p, pre;
    m_scl = 1'b1; m_sda = 1'b1; bank_xor = '0; rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 reg_addr", {16'd0, reg_addr}, 32'd0);

    for (int vi = 0; vi < 4; vi++) begin
      p = VEC[vi][31:16];
      set_ptr(p, acks);
      chk("R3 pointer acks", {29'd0, acks}, 32'd7);
      chk("R3 pointer value", {16'd0, reg_addr}, {16'd0, p});
      bus_start();
      wbyte(8'h71, a);
      chk("R2 read address ack", {31'd0, a}, 32'd1);
      for (int k = 0; k < int'(VEC[vi][15:0]); k++) begin
        read_reg(k == int'(VEC[vi][15:0]) - 1, v);
        if (k == 0) chk("R4 register bytes", v, bank_val(p));
        else if (p == VEC[vi][31:16] + 16'(k)) chk("R5 next register", v, bank_val(p));
        else chk("R6 held pointer", v, bank_val(p));
        if (p >= 16'hE880 && p < 16'hE89F) p = p + 16'd1;
      end
      bus_stop();
      chk("R10 released after stop", {31'd0, sda_oe}, 32'd0);
    end

    // R2: foreign address ignored, pointer untouched
    pre = reg_addr;
    bus_start();
    wbyte(8'h72, a);
    chk("R2 foreign address nack", {31'd0, a}, 32'd0);
    wbyte(8'h12, a);
    chk("R2 following byte nack", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R2 pointer unchanged", {16'd0, reg_addr}, {16'd0, pre});

    // R9: value captured at start of register
    set_ptr(16'hE884, acks);
    bus_start();
    wbyte(8'h71, a);
    rbyte(1'b1, b);
    v = {24'd0, b};
    bank_xor = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      rbyte(1'b1, b);
      v = {v[23:0], b};
    end
    chk("R9 captured word", v, bank_val(16'hE884));
    read_reg(1'b1, v);
    chk("R9 next word uses new data", v, bank_val(16'hE885) ^ 32'hFFFF_FFFF);
    bus_stop();
    bank_xor = '0;

    // R7: NACK at last byte releases SDA
    set_ptr(16'hE890, acks);
    bus_start();
    wbyte(8'h71, a);
    read_reg(1'b1, v);
    chk("R4 single register", v, bank_val(16'hE890));
    rbyte(1'b0, b);
    chk("R7 released after final nack", {24'd0, b}, 32'hFF);
    bus_stop();

    // R8: NACK in the middle of a register
    set_ptr(16'hE890, acks);
    bus_start();
    wbyte(8'h71, a);
    rbyte(1'b0, b);
    chk("R8 first byte", {24'd0, b}, {24'd0, bank_val(16'hE890)[31:24]});
    rbyte(1'b0, b);
    chk("R8 released mid register", {24'd0, b}, 32'hFF);
    bus_stop();
    chk("R8 pointer not advanced", {16'd0, reg_addr}, 32'h0000E890);

    // R10: bytes without START are not acknowledged
    m_scl = 1'b0; wq();
    wbyte(8'h71, a);
    chk("R10 idle ignores bytes", {31'd0, a}, 32'd0);
    bus_stop();

    chk("R11 pull-down only with SCL low", viol, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule